// File: doc/BRIEF.md
# Sense-Reversing Barrier Synchronizer

This unit makes a group of `NUM_REQ` requesters meet at a common point. A requester signals that it has reached the point with a one-cycle `arrive_i` pulse. It then waits until the unit pulses its `release_o` line. Inside the unit, a round-robin arbiter stands in for a lock. It admits at most one arrival per cycle into a shared arrival counter. When the counter reaches the group size, it returns to zero and copies the last arriver's sense bit into a single global release flag.

Each requester keeps its own sense bit and inverts it when it arrives. A requester is released once the global flag equals its own sense. The flag is never cleared between episodes; it only takes the newest sense value. For that reason, a barrier can follow straight after another barrier on the same counter and flag without a slow requester getting stuck.

Each requester is handled by a three-state machine:
- **RQ_IDLE** moves to **RQ_QUEUED** on `arrive_i` (the "arrive" transition, which also flips the sense bit).
- **RQ_QUEUED** moves to **RQ_WAIT** when the arbiter grants it (the "counted" transition).
- **RQ_WAIT** moves back to **RQ_IDLE** in the cycle the flag matches its sense (the "released" transition, during which `release_o` is high).

An `arrive_i` pulse in any state other than RQ_IDLE is a protocol error. It is reported on `early_err_o` and otherwise ignored.

Top module: `barrier_unit`

## Requirements
- R1: After reset the arrival counter is zero, the global flag is 0, every local sense bit is 0, and `release_o` and `early_err_o` are all low.
- R2: The arrival counter advances by at most one per cycle. Simultaneous pending arrivals are granted in round-robin order, and every accepted arrival is counted exactly once.
- R3: When the count reaches `NUM_REQ`, the counter returns to zero and the global flag takes the sense bit of the requester just counted. The flag changes at no other time.
- R4: An `arrive_i` pulse seen in RQ_IDLE inverts that requester's sense bit and moves it to RQ_QUEUED.
- R5: A requester in RQ_WAIT drives `release_o` high for exactly one cycle, the cycle in which the flag equals its sense bit, and then returns to RQ_IDLE. `release_o` first rises in the cycle after the clock edge that counts the last arrival.
- R6: All requesters are released in the same cycle.
- R7: An `arrive_i` pulse seen while a requester is in RQ_QUEUED or RQ_WAIT (including its release cycle) raises that requester's `early_err_o` bit in the same cycle. The pulse changes neither its sense bit nor the count.
- R8: Barrier episodes may follow back to back, and an asynchronous reset in the middle of an episode discards it. In both cases every later episode completes with the same timing as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arrive_i | input | NUM_REQ | One-cycle arrival pulse per requester |
| release_o | output | NUM_REQ | One-cycle release pulse per requester |
| early_err_o | output | NUM_REQ | Arrival seen before the previous release completed |

## Verification
The hardest situation to reach is a second arrival from a requester that has already been counted while others are still queued. The error path must be exercised there without disturbing the count. The stimulus table staggers single arrivals, re-pulses an already counted requester mid-episode, and pulses another one exactly in its release cycle. The release timing of the following episode then shows that neither pulse was counted. An all-at-once arrival right after that checks that the reversed sense lets the next barrier run on the same flag.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
    typedef enum logic [1:0] {
        RQ_IDLE   = 2'd0,
        RQ_QUEUED = 2'd1,
        RQ_WAIT   = 2'd2
    } rq_state_e;
endpackage

// File: rtl/barrier_req_fsm.sv
module barrier_req_fsm
    import barrier_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arrive_i,
    input  logic grant_i,
    input  logic flag_i,
    output logic req_o,
    output logic sense_o,
    output logic release_o,
    output logic err_o
);
    rq_state_e state_q, state_d;
    logic      sense_q, sense_d;

    // next state
    always_comb begin
        state_d = state_q;
        sense_d = sense_q;
        unique case (state_q)
            RQ_IDLE: begin
                if (arrive_i) begin
                    state_d = RQ_QUEUED;
                    sense_d = ~sense_q;
                end
            end
            RQ_QUEUED: begin
                if (grant_i) state_d = RQ_WAIT;
            end
            RQ_WAIT: begin
                if (flag_i == sense_q) state_d = RQ_IDLE;
            end
            default: state_d = RQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RQ_IDLE;
            sense_q <= 1'b0;
        end else begin
            state_q <= state_d;
            sense_q <= sense_d;
        end
    end

    // outputs
    always_comb begin
        req_o     = (state_q == RQ_QUEUED);
        sense_o   = sense_q;
        release_o = (state_q == RQ_WAIT) && (flag_i == sense_q);
        err_o     = arrive_i && (state_q != RQ_IDLE);
    end

    AST_SENSE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RQ_IDLE && arrive_i) |=> (sense_q != $past(sense_q) && state_q == RQ_QUEUED)); // R4
    AST_RELEASE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> (state_q == RQ_IDLE)); // R5
    AST_EARLY_KEEPS_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> $stable(sense_q)); // R7
endmodule

// File: rtl/barrier_rr_arb.sv
module barrier_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] win_idx;
    logic             found;

    always_comb begin
        int idx;
        grant_o = '0;
        win_idx = '0;
        found   = 1'b0;
        idx     = 0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr_q) + k) % N;
            if (!found && req_i[idx]) begin
                grant_o[idx] = 1'b1;
                win_idx      = IDX_W'(idx);
                found        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (found) begin
            ptr_q <= (int'(win_idx) == N - 1) ? '0 : win_idx + IDX_W'(1);
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R2
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0); // R2
    AST_PENDING_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |-> (|grant_o)); // R2
endmodule

// File: rtl/barrier_count.sv
module barrier_count #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic sense_i,
    output logic flag_o
);
    localparam int           CNT_W = $clog2(N + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

    logic [CNT_W-1:0] count_q;
    logic             flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            flag_q  <= 1'b0;
        end else if (inc_i) begin
            if (count_q == LAST) begin
                count_q <= '0;
                flag_q  <= sense_i;
            end else begin
                count_q <= count_q + CNT_W'(1);
            end
        end
    end

    assign flag_o = flag_q;

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LAST); // R3
    AST_FLAG_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q != $past(flag_q)) |-> ($past(inc_i) && $past(count_q) == LAST)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && count_q != LAST) |=> (count_q == $past(count_q) + CNT_W'(1))); // R2
endmodule

// File: rtl/barrier_unit.sv
module barrier_unit #(
    parameter int NUM_REQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] arrive_i,
    output logic [NUM_REQ-1:0] release_o,
    output logic [NUM_REQ-1:0] early_err_o
);
    logic [NUM_REQ-1:0] req;
    logic [NUM_REQ-1:0] grant;
    logic [NUM_REQ-1:0] sense;
    logic               flag;
    logic               win_sense;

    generate
        for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
            barrier_req_fsm u_fsm (
                .clk       (clk),
                .rst_n     (rst_n),
                .arrive_i  (arrive_i[g]),
                .grant_i   (grant[g]),
                .flag_i    (flag),
                .req_o     (req[g]),
                .sense_o   (sense[g]),
                .release_o (release_o[g]),
                .err_o     (early_err_o[g])
            );
        end
    endgenerate

    barrier_rr_arb #(.N(NUM_REQ)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .grant_o (grant)
    );

    assign win_sense = |(grant & sense);

    barrier_count #(.N(NUM_REQ)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (|grant),
        .sense_i (win_sense),
        .flag_o  (flag)
    );

    AST_RELEASE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (|release_o) |-> (&release_o)); // R6
    AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|release_o) |=> (release_o == '0)); // R5
endmodule

// File: tb/barrier_unit_tb.sv
`timescale 1ns/1ps
module barrier_unit_tb_top;
    localparam int P = 4;
    localparam int NV = 19;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [P-1:0] arrive = '0;
    logic [P-1:0] rel;
    logic [P-1:0] err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    barrier_unit #(.NUM_REQ(P)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .arrive_i    (arrive),
        .release_o   (rel),
        .early_err_o (err)
    );

    // {arrive, expected release, expected early error}, one entry per cycle
    localparam logic [11:0] VEC [NV] = '{
        {4'b1111, 4'b0000, 4'b0000}, // all arrive together (R2)
        {4'b0000, 4'b0000, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000}, // fourth grant here
        {4'b0000, 4'b1111, 4'b0000}, // release (R5, R6)
        {4'b0001, 4'b0000, 4'b0000}, // staggered episode (R4)
        {4'b0010, 4'b0000, 4'b0000},
        {4'b0001, 4'b0000, 4'b0001}, // req0 re-pulses while waiting (R7)
        {4'b0100, 4'b0000, 4'b0000},
        {4'b1000, 4'b0000, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000}, // last one counted
        {4'b0010, 4'b1111, 4'b0010}, // re-pulse in release cycle (R7)
        {4'b1111, 4'b0000, 4'b0000}, // back-to-back barrier (R8)
        {4'b0000, 4'b0000, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000},
        {4'b0000, 4'b1111, 4'b0000}
    };

    task automatic check(input string tag, input logic [P-1:0] act, input logic [P-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 release after reset", rel, '0);
        check("R1 error after reset", err, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            arrive = VEC[i][11:8];
            #1;
            check($sformatf("R5/R6 release vector %0d", i), rel, VEC[i][7:4]);
            check($sformatf("R7 early error vector %0d", i), err, VEC[i][3:0]);
        end
        @(negedge clk);
        arrive = '0;
        #1;
        check("R5 single-cycle release", rel, '0);

        // partial episode then reset: discarded (R8, R1)
        @(negedge clk);
        arrive = 4'b0011;
        @(negedge clk);
        arrive = '0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 release during reset", rel, '0);
        @(negedge clk);
        rst_n = 1'b1;
        arrive = 4'b1111;
        #1;
        check("R1 no early error after reset", err, '0);
        for (int c = 1; c <= 4; c++) begin
            @(negedge clk);
            arrive = '0;
            #1;
            check($sformatf("R2 no release before all counted cycle %0d", c), rel, '0);
        end
        @(negedge clk);
        #1;
        check("R8 release after reset mid-episode", rel, 4'b1111);

        // lone stragglers: three in, no release until the fourth (R3)
        @(negedge clk);
        arrive = 4'b0111;
        @(negedge clk);
        arrive = '0;
        repeat (5) @(negedge clk);
        #1;
        check("R3 no release with count short of group", rel, '0);
        arrive = 4'b1000;
        @(negedge clk);
        arrive = '0;
        #1;
        check("R3 not yet released while last queued", rel, '0);
        @(negedge clk);
        #1;
        check("R3 release after last arrival", rel, 4'b1111);
        @(negedge clk);
        #1;
        check("R5 back to idle", rel, '0);

        finish_run();
    end
endmodule